// File: doc/BRIEF.md
# Receive Buffer Scatter Engine

This block stores one accepted Ethernet frame into memory through a linked chain of receive buffer descriptors. A frame descriptor names the first buffer descriptor of the chain and the frame descriptor that follows. The engine walks the chain one buffer at a time. For each buffer it reads the capacity and the data address, then copies as many bytes as fit. Frame bytes come first, and the four CRC bytes follow as trailing payload, so the CRC may straddle a buffer boundary. It then writes the stored count back into the buffer descriptor with fill and end-of-frame flags.

When the frame is stored, or the chain runs out, the engine takes the link of the last buffer it used and hands it to the next frame descriptor, so the next frame starts on the first unused buffer. It then writes the completion status of the current frame descriptor and pulses a done strobe, which serves as the receive interrupt. If the frame descriptor asked to suspend the receiver afterwards, a second strobe reports that the receive unit left the active state. Frame data arrives as a byte stream with a ready/valid handshake. The CRC value and the broadcast/multicast indication are supplied with the start request. Memory is a 16-bit, big-endian, word-addressed port with byte enables and a one-cycle read latency.

Top module: `rx_scatter_engine`

## Requirements
- R1: On `start` in idle, the engine reads the command word at frame descriptor +2, whose bit 14 is the suspend request. It reads the next frame descriptor pointer at +4 and the first buffer descriptor pointer at +8. Every pointer in memory is two 16-bit words, low half at the lower address.
- R2: A buffer descriptor holds its link at +4, its data byte address at +8 and its capacity word at +12. The capacity is the low 14 bits of that word, and bit 15 marks the last buffer of the chain.
- R3: Each buffer receives min(capacity, remaining) bytes, where remaining starts at frame length + 4. Frame bytes go first, in stream order, then CRC bytes, most significant byte first. The CRC may be split across buffers.
- R4: After a buffer is filled, its descriptor word at +0 is written with the byte count in bits 13:0 and bit 14 set. Bit 15 is also set when no bytes remain.
- R5: The chain walk stops after a buffer marked last or once nothing remains. Frame bytes still unstored are then accepted from the stream and discarded. Unstored CRC bytes are dropped.
- R6: The link of the last buffer used is written to the next frame descriptor at +8/+10.
- R7: After all buffer writes, the frame descriptor word at +0 is written as 0xA000 ORed with 1 when `frame_bcast` was set.
- R8: `done` pulses for one cycle after the status write, with `busy` already low. `ru_left` pulses together with `done` exactly when the suspend request was set.
- R9: In memory, the even byte of a word sits in bits 15:8 under `mem_be[1]` and the odd byte in bits 7:0 under `mem_be[0]`. Each data byte is written alone with one byte enable.
- R10: `in_ready` is low in idle, during every descriptor read and during descriptor writes. A stream held invalid stalls the transfer without loss.
- R11: `start` is ignored while `busy` is high.
- R12: After reset the engine is idle, with `busy`, `in_ready`, `mem_req`, `done` and `ru_left` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin storing a frame (sampled in idle) |
| frame_len | input | LEN_W | Frame length in bytes, without CRC |
| frame_crc | input | 32 | CRC value appended after the frame |
| frame_bcast | input | 1 | Frame was broadcast or multicast |
| rfd_addr | input | 32 | Byte address of the frame descriptor |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Engine accepts the stream byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 31 | Memory word address |
| mem_be | output | 2 | Byte enables (bit 1 = even byte) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| busy | output | 1 | Engine is processing a frame |
| done | output | 1 | One-cycle frame completion strobe |
| ru_left | output | 1 | Receive unit suspended after this frame |

## Verification
Each buffer's stored count is taken from the live remaining-byte counter. A wrong counter or a wrong split between frame and CRC bytes therefore shows up in the same frame, as a wrong count word, a shifted CRC byte or a misplaced end-of-frame flag in memory. A corrupted link or pointer register writes data to the wrong buffer or hands the wrong pointer to the next frame descriptor. This is visible in the memory image as soon as `done` pulses. A state machine that accepts stream bytes at the wrong time either hangs the stream or leaves it partly unconsumed at `done`, so the error appears within one frame.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_RD_CMD,
    S_RD_NRFD_LO,
    S_RD_NRFD_HI,
    S_RD_RBD_LO,
    S_RD_RBD_HI,
    S_RD_CAP,
    S_RD_RBA_LO,
    S_RD_RBA_HI,
    S_RD_LNK_LO,
    S_RD_LNK_HI,
    S_XFER,
    S_WR_CNT,
    S_DRAIN,
    S_WR_NXT_LO,
    S_WR_NXT_HI,
    S_WR_STAT
  } rxs_state_e;

  // byte offsets inside descriptors
  localparam logic [31:0] OFS_STATUS = 32'd0;
  localparam logic [31:0] OFS_CMD    = 32'd2;
  localparam logic [31:0] OFS_LINK   = 32'd4;
  localparam logic [31:0] OFS_PTR    = 32'd8;
  localparam logic [31:0] OFS_CAP    = 32'd12;
  localparam logic [31:0] OFS_HALF   = 32'd2;

  localparam int CNT_W      = 14;   // count / capacity field width
  localparam int CRC_BYTES  = 4;
  localparam int SUSP_BIT   = 14;   // in the frame command word
  localparam int LAST_BIT   = 15;   // in the capacity word
  localparam logic [15:0] DONE_STATUS = 16'hA000;

endpackage

// File: rtl/rxs_lane_map.sv
module rxs_lane_map (
  input  logic [31:0] byte_addr,
  input  logic [7:0]  byte_data,
  output logic [30:0] word_addr,
  output logic [1:0]  lane_be,
  output logic [15:0] lane_wdata
);
  // big-endian: even byte in the upper half of the word
  always_comb begin
    word_addr  = byte_addr[31:1];
    lane_be    = byte_addr[0] ? 2'b01 : 2'b10;
    lane_wdata = {byte_data, byte_data};
  end
endmodule

// File: rtl/rxs_crc_pick.sv
module rxs_crc_pick (
  input  logic [31:0] crc,
  input  logic [2:0]  left,
  output logic [7:0]  crc_byte
);
  // left counts down 4..1; most significant byte leaves first
  always_comb begin
    unique case (left)
      3'd4:    crc_byte = crc[31:24];
      3'd3:    crc_byte = crc[23:16];
      3'd2:    crc_byte = crc[15:8];
      3'd1:    crc_byte = crc[7:0];
      default: crc_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/rxs_fit.sv
module rxs_fit #(
  parameter int REM_W = 15,
  parameter int CAP_W = 14
) (
  input  logic [CAP_W-1:0] capacity,
  input  logic [REM_W-1:0] remain,
  output logic [CAP_W-1:0] fit_num
);
  localparam int CW = (REM_W > CAP_W) ? REM_W : CAP_W;

  logic [CW-1:0] cap_x;
  logic [CW-1:0] rem_x;
  logic [CW-1:0] min_x;

  always_comb begin
    cap_x   = CW'(capacity);
    rem_x   = CW'(remain);
    min_x   = (cap_x < rem_x) ? cap_x : rem_x;
    fit_num = min_x[CAP_W-1:0];
  end
endmodule

// File: rtl/rx_scatter_engine.sv
module rx_scatter_engine
  import rxs_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [31:0]      frame_crc,
  input  logic             frame_bcast,
  input  logic [31:0]      rfd_addr,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [30:0]      mem_addr,
  output logic [1:0]       mem_be,
  output logic [15:0]      mem_wdata,
  input  logic [15:0]      mem_rdata,
  output logic             busy,
  output logic             done,
  output logic             ru_left
);

  localparam int REM_W = LEN_W + 1;

  rxs_state_e       state_q, state_n;
  logic             rd_wait_q, rd_wait_n;
  logic [31:0]      rfd_q, rfd_n;
  logic [31:0]      nrfd_q, nrfd_n;
  logic [31:0]      rbd_q, rbd_n;
  logic [31:0]      link_q, link_n;
  logic [31:0]      wptr_q, wptr_n;
  logic             susp_q, susp_n;
  logic             last_q, last_n;
  logic [CNT_W-1:0] bleft_q, bleft_n;
  logic [CNT_W-1:0] bnum_q, bnum_n;
  logic [LEN_W-1:0] fleft_q, fleft_n;
  logic [2:0]       cleft_q, cleft_n;
  logic [31:0]      crc_q, crc_n;
  logic             bc_q, bc_n;
  logic             done_q, done_n;
  logic             ru_q, ru_n;

  logic [REM_W-1:0] remain;
  logic [CNT_W-1:0] fit_num;
  logic [7:0]       crc_byte;
  logic [7:0]       out_byte;
  logic [31:0]      acc_byte;
  logic             is_byte;
  logic [15:0]      word_wdata;
  logic [30:0]      lane_addr;
  logic [1:0]       lane_be;
  logic [15:0]      lane_wdata;
  logic             frame_pending;
  logic             buf_open;

  assign remain        = REM_W'(fleft_q) + REM_W'(cleft_q);
  assign frame_pending = (fleft_q != '0);
  assign buf_open      = (bleft_q != '0);

  rxs_fit #(.REM_W(REM_W), .CAP_W(CNT_W)) u_fit (
    .capacity (mem_rdata[CNT_W-1:0]),
    .remain   (remain),
    .fit_num  (fit_num)
  );

  rxs_crc_pick u_crc (
    .crc      (crc_q),
    .left     (cleft_q),
    .crc_byte (crc_byte)
  );

  assign out_byte = frame_pending ? in_data : crc_byte;

  rxs_lane_map u_lane (
    .byte_addr  (acc_byte),
    .byte_data  (out_byte),
    .word_addr  (lane_addr),
    .lane_be    (lane_be),
    .lane_wdata (lane_wdata)
  );

  // ---------------- next-state logic ----------------
  always_comb begin
    state_n   = state_q;
    rd_wait_n = rd_wait_q;
    rfd_n     = rfd_q;
    nrfd_n    = nrfd_q;
    rbd_n     = rbd_q;
    link_n    = link_q;
    wptr_n    = wptr_q;
    susp_n    = susp_q;
    last_n    = last_q;
    bleft_n   = bleft_q;
    bnum_n    = bnum_q;
    fleft_n   = fleft_q;
    cleft_n   = cleft_q;
    crc_n     = crc_q;
    bc_n      = bc_q;
    done_n    = 1'b0;
    ru_n      = 1'b0;

    mem_req    = 1'b0;
    mem_we     = 1'b0;
    acc_byte   = rfd_q;
    is_byte    = 1'b0;
    word_wdata = 16'h0000;
    in_ready   = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          rfd_n     = rfd_addr;
          fleft_n   = frame_len;
          cleft_n   = 3'(CRC_BYTES);
          crc_n     = frame_crc;
          bc_n      = frame_bcast;
          rd_wait_n = 1'b0;
          state_n   = S_RD_CMD;
        end
      end

      S_RD_CMD: begin
        acc_byte  = rfd_q + OFS_CMD;
        mem_req   = !rd_wait_q;
        rd_wait_n = !rd_wait_q;
        if (rd_wait_q) begin
          susp_n  = mem_rdata[SUSP_BIT];
          state_n = S_RD_NRFD_LO;
        end
      end

      S_RD_NRFD_LO: begin
        acc_byte  = rfd_q + OFS_LINK;
        mem_req   = !rd_wait_q;
        rd_wait_n = !rd_wait_q;
        if (rd_wait_q) begin
          nrfd_n[15:0] = mem_rdata;
          state_n      = S_RD_NRFD_HI;
        end
      end

      S_RD_NRFD_HI: begin
        acc_byte  = rfd_q + OFS_LINK + OFS_HALF;
        mem_req   = !rd_wait_q;
        rd_wait_n = !rd_wait_q;
        if (rd_wait_q) begin
          nrfd_n[31:16] = mem_rdata;
          state_n       = S_RD_RBD_LO;
        end
      end

      S_RD_RBD_LO: begin
        acc_byte  = rfd_q + OFS_PTR;
        mem_req   = !rd_wait_q;
        rd_wait_n = !rd_wait_q;
        if (rd_wait_q) begin
          rbd_n[15:0] = mem_rdata;
          state_n     = S_RD_RBD_HI;
        end
      end

      S_RD_RBD_HI: begin
        acc_byte  = rfd_q + OFS_PTR + OFS_HALF;
        mem_req   = !rd_wait_q;
        rd_wait_n = !rd_wait_q;
        if (rd_wait_q) begin
          rbd_n[31:16] = mem_rdata;
          state_n      = S_RD_CAP;
        end
      end

      S_RD_CAP: begin
        acc_byte  = rbd_q + OFS_CAP;
        mem_req   = !rd_wait_q;
        rd_wait_n = !rd_wait_q;
        if (rd_wait_q) begin
          last_n  = mem_rdata[LAST_BIT];
          bleft_n = fit_num;
          bnum_n  = fit_num;
          state_n = S_RD_RBA_LO;
        end
      end

      S_RD_RBA_LO: begin
        acc_byte  = rbd_q + OFS_PTR;
        mem_req   = !rd_wait_q;
        rd_wait_n = !rd_wait_q;
        if (rd_wait_q) begin
          wptr_n[15:0] = mem_rdata;
          state_n      = S_RD_RBA_HI;
        end
      end

      S_RD_RBA_HI: begin
        acc_byte  = rbd_q + OFS_PTR + OFS_HALF;
        mem_req   = !rd_wait_q;
        rd_wait_n = !rd_wait_q;
        if (rd_wait_q) begin
          wptr_n[31:16] = mem_rdata;
          state_n       = S_RD_LNK_LO;
        end
      end

      S_RD_LNK_LO: begin
        acc_byte  = rbd_q + OFS_LINK;
        mem_req   = !rd_wait_q;
        rd_wait_n = !rd_wait_q;
        if (rd_wait_q) begin
          link_n[15:0] = mem_rdata;
          state_n      = S_RD_LNK_HI;
        end
      end

      S_RD_LNK_HI: begin
        acc_byte  = rbd_q + OFS_LINK + OFS_HALF;
        mem_req   = !rd_wait_q;
        rd_wait_n = !rd_wait_q;
        if (rd_wait_q) begin
          link_n[31:16] = mem_rdata;
          state_n       = S_XFER;
        end
      end

      S_XFER: begin
        acc_byte = wptr_q;
        is_byte  = 1'b1;
        if (!buf_open) begin
          state_n = S_WR_CNT;
        end else if (frame_pending) begin
          in_ready = 1'b1;
          if (in_valid) begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            wptr_n  = wptr_q + 32'd1;
            bleft_n = bleft_q - 1'b1;
            fleft_n = fleft_q - 1'b1;
          end
        end else begin
          mem_req = 1'b1;
          mem_we  = 1'b1;
          wptr_n  = wptr_q + 32'd1;
          bleft_n = bleft_q - 1'b1;
          cleft_n = cleft_q - 3'd1;
        end
      end

      S_WR_CNT: begin
        acc_byte   = rbd_q + OFS_STATUS;
        mem_req    = 1'b1;
        mem_we     = 1'b1;
        word_wdata = {(remain == '0), 1'b1, bnum_q};
        rbd_n      = link_q;
        rd_wait_n  = 1'b0;
        if (last_q || (remain == '0)) begin
          state_n = frame_pending ? S_DRAIN : S_WR_NXT_LO;
        end else begin
          state_n = S_RD_CAP;
        end
      end

      S_DRAIN: begin
        in_ready = frame_pending;
        if (!frame_pending) begin
          state_n = S_WR_NXT_LO;
        end else if (in_valid) begin
          fleft_n = fleft_q - 1'b1;
        end
      end

      S_WR_NXT_LO: begin
        acc_byte   = nrfd_q + OFS_PTR;
        mem_req    = 1'b1;
        mem_we     = 1'b1;
        word_wdata = rbd_q[15:0];
        state_n    = S_WR_NXT_HI;
      end

      S_WR_NXT_HI: begin
        acc_byte   = nrfd_q + OFS_PTR + OFS_HALF;
        mem_req    = 1'b1;
        mem_we     = 1'b1;
        word_wdata = rbd_q[31:16];
        state_n    = S_WR_STAT;
      end

      S_WR_STAT: begin
        acc_byte   = rfd_q + OFS_STATUS;
        mem_req    = 1'b1;
        mem_we     = 1'b1;
        word_wdata = DONE_STATUS | {15'd0, bc_q};
        done_n     = 1'b1;
        ru_n       = susp_q;
        state_n    = S_IDLE;
      end

      default: state_n = S_IDLE;
    endcase
  end

  // memory port assembly
  always_comb begin
    mem_addr  = lane_addr;
    mem_be    = is_byte ? lane_be : 2'b11;
    mem_wdata = is_byte ? lane_wdata : word_wdata;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      rd_wait_q <= 1'b0;
      rfd_q     <= '0;
      nrfd_q    <= '0;
      rbd_q     <= '0;
      link_q    <= '0;
      wptr_q    <= '0;
      susp_q    <= 1'b0;
      last_q    <= 1'b0;
      bleft_q   <= '0;
      bnum_q    <= '0;
      fleft_q   <= '0;
      cleft_q   <= '0;
      crc_q     <= '0;
      bc_q      <= 1'b0;
      done_q    <= 1'b0;
      ru_q      <= 1'b0;
    end else begin
      state_q   <= state_n;
      rd_wait_q <= rd_wait_n;
      rfd_q     <= rfd_n;
      nrfd_q    <= nrfd_n;
      rbd_q     <= rbd_n;
      link_q    <= link_n;
      wptr_q    <= wptr_n;
      susp_q    <= susp_n;
      last_q    <= last_n;
      bleft_q   <= bleft_n;
      bnum_q    <= bnum_n;
      fleft_q   <= fleft_n;
      cleft_q   <= cleft_n;
      crc_q     <= crc_n;
      bc_q      <= bc_n;
      done_q    <= done_n;
      ru_q      <= ru_n;
    end
  end

  assign busy    = (state_q != S_IDLE);
  assign done    = done_q;
  assign ru_left = ru_q;

endmodule

// File: rtl/rx_scatter_engine_chk.sv
module rx_scatter_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        in_valid,
  input logic        in_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [1:0]  mem_be,
  input logic        busy,
  input logic        done,
  input logic        ru_left
);

  AST_READY_NOT_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !in_ready);                              // R10

  AST_READY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);                                               // R10

  AST_DATA_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && in_valid && in_ready) |-> ($countones(mem_be) == 1)); // R9

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                  // R8

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                  // R8

  AST_RU_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ru_left |-> done);                                                // R8

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));                                    // R11

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);                                              // R12

endmodule

bind rx_scatter_engine rx_scatter_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_be   (mem_be),
  .busy     (busy),
  .done     (done),
  .ru_left  (ru_left)
);

// File: tb/rx_scatter_engine_bench.sv
module rx_scatter_engine_bench;

  localparam int LEN_W = 14;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [LEN_W-1:0] frame_len;
  logic [31:0]      frame_crc;
  logic             frame_bcast;
  logic [31:0]      rfd_addr;
  logic             in_valid;
  logic [7:0]       in_data;
  logic             in_ready;
  logic             mem_req;
  logic             mem_we;
  logic [30:0]      mem_addr;
  logic [1:0]       mem_be;
  logic [15:0]      mem_wdata;
  logic [15:0]      mem_rdata;
  logic             busy;
  logic             done;
  logic             ru_left;

  int checks;
  int errors;
  bit finished;

  rx_scatter_engine #(.LEN_W(LEN_W)) u_rx_scatter_engine (
    .clk (clk), .rst_n (rst_n), .start (start), .frame_len (frame_len),
    .frame_crc (frame_crc), .frame_bcast (frame_bcast), .rfd_addr (rfd_addr),
    .in_valid (in_valid), .in_data (in_data), .in_ready (in_ready),
    .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr), .mem_be (mem_be),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .busy (busy), .done (done),
    .ru_left (ru_left)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // memory model: one-cycle read latency, big-endian lanes
  logic [15:0] mem   [0:4095];
  logic [15:0] exp_m [0:4095];

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        if (mem_be[1]) mem[mem_addr[11:0]][15:8] <= mem_wdata[15:8];
        if (mem_be[0]) mem[mem_addr[11:0]][7:0]  <= mem_wdata[7:0];
      end else begin
        mem_rdata <= mem[mem_addr[11:0]];
      end
    end
  end

  // R10: no stream acceptance while a descriptor read is on the port
  int ready_in_fetch;
  always @(negedge clk) begin
    if (rst_n && in_ready && mem_req && !mem_we) ready_in_fetch++;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic put_w(input logic [31:0] a, input logic [15:0] w);
    mem[a[12:1]]   = w;
    exp_m[a[12:1]] = w;
  endtask

  task automatic put_p(input logic [31:0] a, input logic [31:0] p);
    put_w(a, p[15:0]);
    put_w(a + 2, p[31:16]);
  endtask

  function automatic logic [15:0] ew(input logic [31:0] a);
    return exp_m[a[12:1]];
  endfunction

  function automatic logic [31:0] ep(input logic [31:0] a);
    return {ew(a + 2), ew(a)};
  endfunction

  task automatic e_byte(input logic [31:0] a, input logic [7:0] b);
    if (a[0]) exp_m[a[12:1]][7:0]  = b;
    else      exp_m[a[12:1]][15:8] = b;
  endtask

  task automatic e_word(input logic [31:0] a, input logic [15:0] w);
    exp_m[a[12:1]] = w;
  endtask

  localparam logic [31:0] RFD  = 32'h0100;
  localparam logic [31:0] NRFD = 32'h0140;
  localparam logic [31:0] ALT  = 32'h0180;
  localparam logic [31:0] RBD0 = 32'h0200;
  localparam logic [31:0] BUF0 = 32'h0800;
  localparam logic [31:0] TAIL = 32'h1E00;

  int          caps [0:15];
  logic [7:0]  fdata [0:255];

  // builds a frame descriptor and a chain of nb buffers (R1, R2 layout)
  task automatic build(input int nb, input bit susp, input bit odd);
    put_w(RFD + 2, {1'b0, susp, 14'd0});
    put_p(RFD + 4, NRFD);
    put_p(RFD + 8, RBD0);
    for (int k = 0; k < nb; k++) begin
      logic [31:0] d;
      d = RBD0 + 32'h20 * k;
      put_w(d, 16'h5A5A);
      put_p(d + 4, (k == nb - 1) ? TAIL : d + 32'h20);
      put_p(d + 8, BUF0 + 32'h100 * k + (odd ? 1 : 0));
      put_w(d + 12, {(k == nb - 1), 1'b0, 14'(caps[k])});
    end
    // alternate descriptor that must never be processed (R11)
    put_w(ALT + 2, 16'h0000);
    put_p(ALT + 4, NRFD);
    put_p(ALT + 8, RBD0);
  endtask

  // independent expected-image computation from R3..R7
  task automatic model(input int len, input logic [31:0] crc, input bit bc);
    int          rem, fi, ci;
    logic [31:0] rbd, nrfd;
    rem  = len + 4;
    fi   = 0;
    ci   = 0;
    rbd  = ep(RFD + 8);
    nrfd = ep(RFD + 4);
    forever begin
      logic [15:0] capw;
      logic [31:0] rba;
      int          n;
      capw = ew(rbd + 12);
      n    = (int'(capw[13:0]) < rem) ? int'(capw[13:0]) : rem;
      rba  = ep(rbd + 8);
      for (int k = 0; k < n; k++) begin
        if (fi < len) begin
          e_byte(rba + k, fdata[fi]);
          fi++;
        end else begin
          e_byte(rba + k, crc[31 - 8*ci -: 8]);
          ci++;
        end
      end
      rem = rem - n;
      e_word(rbd, {(rem == 0), 1'b1, 14'(n)});
      rbd = ep(rbd + 4);
      if (capw[15] || rem == 0) break;
    end
    e_word(nrfd + 8, rbd[15:0]);
    e_word(nrfd + 10, rbd[31:16]);
    e_word(RFD, 16'hA000 | {15'd0, bc});
  endtask

  task automatic run_frame(input string tag, input int len, input int nb,
                           input bit susp, input bit odd, input bit bc,
                           input bit poke_start);
    logic [31:0] crc;
    int  sent, dones, rus, cyc, mism, first_i;
    bit  got;
    crc = $urandom();
    for (int i = 0; i < 256; i++) fdata[i] = 8'($urandom());
    build(nb, susp, odd);
    model(len, crc, bc);
    ready_in_fetch = 0;

    @(negedge clk);
    start       = 1'b1;
    frame_len   = LEN_W'(len);
    frame_crc   = crc;
    frame_bcast = bc;
    rfd_addr    = RFD;
    @(negedge clk);
    start = 1'b0;

    sent = 0; dones = 0; rus = 0; cyc = 0; got = 0;
    while (!got && cyc < 20000) begin
      // decide this cycle's stream drive
      in_valid = (sent < len) && ($urandom_range(0, 3) != 0);
      in_data  = fdata[sent];
      if (poke_start && cyc == 3) begin
        start    = 1'b1;
        rfd_addr = ALT;
      end else begin
        start = 1'b0;
      end
      #1;
      if (in_valid && in_ready) sent++;
      @(negedge clk);
      if (done) begin
        got = 1;
        dones++;
        if (ru_left) rus++;
      end
      cyc++;
    end
    in_valid = 1'b0;
    start    = 1'b0;
    rfd_addr = RFD;

    check(got, "R8", {tag, " done seen"}, got, 1);
    check(rus == (susp ? 1 : 0), "R8", {tag, " ru_left with done"}, rus, susp);
    check(sent == len, "R5", {tag, " stream bytes consumed"}, sent, len);

    // no further activity (start during busy must be ignored)
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check(dones == 1, "R11", {tag, " single completion"}, dones, 1);
    check(ready_in_fetch == 0, "R10", {tag, " ready during fetch"}, ready_in_fetch, 0);

    // R1 R2 R3 R4 R6 R7 R9: whole memory image
    mism = 0; first_i = -1;
    for (int i = 0; i < 4096; i++) begin
      if (mem[i] !== exp_m[i]) begin
        if (first_i < 0) first_i = i;
        mism++;
      end
    end
    if (first_i < 0) first_i = 0;
    check(mism == 0, "R3/R4/R6/R7",
          $sformatf("%s memory image word %0h", tag, first_i),
          mem[first_i], exp_m[first_i]);
  endtask

  // global watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0; frame_len = '0; frame_crc = '0;
    frame_bcast = 1'b0; rfd_addr = RFD; in_valid = 1'b0; in_data = 8'h00;
    for (int i = 0; i < 4096; i++) begin
      mem[i]   = 16'($urandom());
      exp_m[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!busy,     "R12", "busy in reset",     busy, 0);
    check(!mem_req,  "R12", "mem_req in reset",  mem_req, 0);
    check(!in_ready, "R12", "in_ready in reset", in_ready, 0);
    check(!done && !ru_left, "R12", "strobes in reset", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !mem_req, "R12", "idle after release", busy, 0);

    // R3: CRC split across buffers (6 frame | 2 frame + 1 CRC | 3 CRC)
    caps[0] = 6; caps[1] = 3; caps[2] = 8;
    run_frame("crc-split", 8, 3, 0, 0, 0, 0);
    // R4: exact fit, EOF on final buffer
    caps[0] = 7; caps[1] = 7;
    run_frame("exact-fit", 10, 2, 0, 0, 1, 0);
    // R5: chain too short, rest drained
    caps[0] = 8; caps[1] = 8;
    run_frame("truncate", 40, 2, 0, 0, 0, 0);
    // R3: empty frame, only CRC stored
    caps[0] = 2; caps[1] = 5;
    run_frame("crc-only", 0, 2, 0, 0, 0, 0);
    // R8/R7: suspend and broadcast, odd buffer addresses (R9)
    caps[0] = 5; caps[1] = 9; caps[2] = 30;
    run_frame("suspend-odd", 25, 3, 1, 1, 1, 0);
    // R11: start while busy
    caps[0] = 12; caps[1] = 40;
    run_frame("start-busy", 30, 2, 0, 1, 0, 1);
    // R6: frame ends before the chain does
    caps[0] = 20; caps[1] = 20; caps[2] = 20; caps[3] = 20;
    run_frame("early-end", 15, 4, 0, 0, 0, 0);

    for (int t = 0; t < 12; t++) begin
      int nb;
      nb = $urandom_range(1, 6);
      for (int k = 0; k < nb; k++) caps[k] = $urandom_range(1, 40);
      run_frame($sformatf("rand%0d", t), $urandom_range(0, 120), nb,
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule